// File: doc/BRIEF.md
# Shared-Datapath Goertzel DTMF Key Detector

This block finds the telephone key whose two-tone signal is present in a stream of signed samples arriving at 5 kHz. Samples are collected in frames of 128. For each sample, the block advances eight second-order Goertzel recurrences, one per DTMF frequency, with a Q2.14 coefficient equal to 2cos(2πk/128). At 39.0625 Hz per bin, the four low-group bins use k = 18, 20, 22, 24 and the four high-group bins use k = 31, 34, 38, 42. No other bins are computed.

The eight filters do not have their own arithmetic. A single multiplier feeds a single three-operand adder, and a small state machine walks it through the eight bins after each sample. At the end of a frame, the same hardware computes the squared magnitude s1² + s2² − coef·s1·s2 of each bin, four steps per bin.

The strongest bin of each group is then chosen. If both winners clear a minimum level set on an input port, the row/column pair is translated into a 4-bit key code and reported with a one-cycle pulse. The recurrence state is cleared so that the next frame starts fresh.

Top module: `dtmf_goertzel_detector`

## Requirements
- R1: While reset is held and right after it is released, `valid_o` is 0, `digit_o` is 0 and every magnitude on `mag_o` is 0.
- R2: Low bins k = 18, 20, 22, 24 are rows 0 to 3 and high bins k = 31, 34, 38, 42 are columns 0 to 3. Row by row, the reported code is 1,2,3,A / 4,5,6,B / 7,8,9,C / E,0,F,D. A frame carrying one row tone plus one column tone reports the code of that row and column, and this holds for all sixteen codes.
- R3: Bin i sits at `mag_o[i*MAG_W +: MAG_W]`. Bins 0 to 3 are the low group in ascending frequency and bins 4 to 7 are the high group. After a frame, the bin holding each driven tone has a strictly larger magnitude than the other three bins of its group.
- R4: `valid_o` rises exactly 41 clock edges after the edge that captures the 128th sample of a frame (1 capture, 8 update and 32 magnitude cycles). It lasts one cycle. It never appears earlier in the frame.
- R5: A frame is reported only if the largest magnitude in each group is strictly greater than `min_mag_i`. Otherwise `valid_o` stays low for that frame. An all-zero frame with `min_mag_i` = 0 is therefore not reported.
- R6: `digit_o` changes only together with a `valid_o` pulse and holds its value through frames that are not reported.
- R7: The recurrence state of every bin is cleared after each frame. A silent frame that follows a tone frame yields all-zero magnitudes, and consecutive key frames each decode to their own key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_stb_i | input | 1 | One-cycle strobe marking a new sample |
| sample_i | input | SAMPLE_W | Signed input sample |
| min_mag_i | input | MAG_W | Minimum winning magnitude required in both groups |
| digit_o | output | 4 | Key code of the last reported frame |
| valid_o | output | 1 | One-cycle pulse when a frame is reported |
| mag_o | output | 8*MAG_W | Squared magnitudes of the eight bins from the last frame |

## Verification
The checks assume that a sample strobe arrives only while the block is idle. This means strobes are at least 42 cycles apart, which at a real 5 kHz rate is never close. They also assume that the minimum level does not change while a frame's decision is pending, and that tone amplitudes leave headroom in the sample width. The bench spaces its strobes 48 cycles apart and changes the threshold only between frames. It drives tones of amplitude 900 each at exact bin frequencies, so their sum never leaves the 12-bit signed range.

// File: rtl/dtmf_det_pkg.sv
package dtmf_det_pkg;

    localparam int NUM_BINS   = 8;
    localparam int GROUP_BINS = 4;
    localparam int COEF_W     = 16;
    localparam int COEF_FRAC  = 14;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_UPDATE = 2'd1,
        PH_POWER  = 2'd2,
        PH_DECIDE = 2'd3
    } phase_e;

    // 2*cos(2*pi*k/128) in Q2.14 for k = 18,20,22,24,31,34,38,42
    function automatic logic signed [COEF_W-1:0] bin_coef(input logic [2:0] idx);
        logic signed [COEF_W-1:0] c;
        case (idx)
            3'd0:    c = 16'sd20788;
            3'd1:    c = 16'sd18205;
            3'd2:    c = 16'sd15447;
            3'd3:    c = 16'sd12540;
            3'd4:    c = 16'sd1608;
            3'd5:    c = -16'sd3212;
            3'd6:    c = -16'sd9512;
            default: c = -16'sd15447;
        endcase
        return c;
    endfunction

    // row/column pair to key code
    function automatic logic [3:0] key_code(input logic [1:0] row, input logic [1:0] col);
        logic [3:0] k;
        case ({row, col})
            4'b0000: k = 4'h1;
            4'b0001: k = 4'h2;
            4'b0010: k = 4'h3;
            4'b0011: k = 4'hA;
            4'b0100: k = 4'h4;
            4'b0101: k = 4'h5;
            4'b0110: k = 4'h6;
            4'b0111: k = 4'hB;
            4'b1000: k = 4'h7;
            4'b1001: k = 4'h8;
            4'b1010: k = 4'h9;
            4'b1011: k = 4'hC;
            4'b1100: k = 4'hE;
            4'b1101: k = 4'h0;
            4'b1110: k = 4'hF;
            default: k = 4'hD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/dtmf_shared_mac.sv
// Single multiplier feeding a single three-operand adder.
module dtmf_shared_mac #(
    parameter int A_W   = 26,
    parameter int B_W   = 24,
    parameter int ACC_W = 52,
    parameter int FRAC  = 14
) (
    input  logic signed [A_W-1:0]   op_a_i,
    input  logic signed [B_W-1:0]   op_b_i,
    input  logic signed [ACC_W-1:0] base_i,
    input  logic signed [ACC_W-1:0] sub_i,
    input  logic                    scale_i,
    input  logic                    negate_i,
    output logic signed [ACC_W-1:0] result_o
);

    localparam int PROD_W = A_W + B_W;

    logic signed [PROD_W-1:0] product;
    logic signed [ACC_W-1:0]  term;

    always_comb begin
        product = op_a_i * op_b_i;
        if (scale_i) begin
            term = ACC_W'(product >>> FRAC);
        end else begin
            term = ACC_W'(product);
        end
        if (negate_i) begin
            result_o = base_i - sub_i - term;
        end else begin
            result_o = base_i - sub_i + term;
        end
    end

endmodule

// File: rtl/dtmf_peak_pick.sv
// Index and value of the largest magnitude; ties go to the lowest index.
module dtmf_peak_pick #(
    parameter int MAG_W = 48,
    parameter int COUNT = 4
) (
    input  logic [COUNT-1:0][MAG_W-1:0]     mags_i,
    output logic [$clog2(COUNT)-1:0]        idx_o,
    output logic [MAG_W-1:0]                peak_o
);

    localparam int IDX_W = $clog2(COUNT);

    always_comb begin
        peak_o = mags_i[0];
        idx_o  = '0;
        for (int i = 1; i < COUNT; i++) begin
            if (mags_i[i] > peak_o) begin
                peak_o = mags_i[i];
                idx_o  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dtmf_goertzel_detector.sv
module dtmf_goertzel_detector
    import dtmf_det_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int STATE_W   = 24,
    parameter int FRAME_LEN = 128,
    parameter int MAG_W     = 48
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          sample_stb_i,
    input  logic signed [SAMPLE_W-1:0]    sample_i,
    input  logic [MAG_W-1:0]              min_mag_i,
    output logic [3:0]                    digit_o,
    output logic                          valid_o,
    output logic [NUM_BINS*MAG_W-1:0]     mag_o
);

    localparam int NBIN      = NUM_BINS;
    localparam int BIN_W     = $clog2(NBIN);
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int GRP_IDX_W = $clog2(GROUP_BINS);
    localparam int MUL_A_W   = STATE_W + 2;
    localparam int MUL_B_W   = STATE_W;
    localparam int ACC_W     = MUL_A_W + MUL_B_W + 2;

    typedef struct packed {
        phase_e                        fsm;
        logic [BIN_W-1:0]              bin;
        logic [1:0]                    step;
        logic [CNT_W-1:0]              cnt;
        logic [SAMPLE_W-1:0]           x;
        logic [NBIN-1:0][STATE_W-1:0]  s1;
        logic [NBIN-1:0][STATE_W-1:0]  s2;
        logic [ACC_W-1:0]              acc;
        logic [MUL_A_W-1:0]            tmp;
        logic [NBIN-1:0][MAG_W-1:0]    mag;
        logic [3:0]                    digit;
        logic                          valid;
    } regs_t;

    regs_t q, d;

    // shared datapath operands
    logic signed [STATE_W-1:0] s1_cur, s2_cur;
    logic signed [COEF_W-1:0]  coef_cur;
    logic signed [MUL_A_W-1:0] op_a;
    logic signed [MUL_B_W-1:0] op_b;
    logic signed [ACC_W-1:0]   base, sub, mac_out;
    logic                      scale, negate;

    // group winners
    logic [1:0][GRP_IDX_W-1:0] win_idx;
    logic [1:0][MAG_W-1:0]     win_mag;
    logic                      qualified;

    // observation points for the bound checker
    logic [2*NBIN*STATE_W-1:0] state_vec;
    phase_e                    fsm_now;

    function automatic logic [MAG_W-1:0] to_mag(input logic signed [ACC_W-1:0] v);
        if (v < 0) begin
            return '0;
        end else if (|v[ACC_W-1:MAG_W]) begin
            return '1;
        end else begin
            return v[MAG_W-1:0];
        end
    endfunction

    dtmf_shared_mac #(
        .A_W   (MUL_A_W),
        .B_W   (MUL_B_W),
        .ACC_W (ACC_W),
        .FRAC  (COEF_FRAC)
    ) u_mac (
        .op_a_i   (op_a),
        .op_b_i   (op_b),
        .base_i   (base),
        .sub_i    (sub),
        .scale_i  (scale),
        .negate_i (negate),
        .result_o (mac_out)
    );

    for (genvar g = 0; g < 2; g++) begin : g_group
        dtmf_peak_pick #(
            .MAG_W (MAG_W),
            .COUNT (GROUP_BINS)
        ) u_pick (
            .mags_i (q.mag[g*GROUP_BINS +: GROUP_BINS]),
            .idx_o  (win_idx[g]),
            .peak_o (win_mag[g])
        );
    end

    assign qualified = (win_mag[0] > min_mag_i) && (win_mag[1] > min_mag_i);

    // operand selection for the current schedule slot
    always_comb begin
        s1_cur   = $signed(q.s1[q.bin]);
        s2_cur   = $signed(q.s2[q.bin]);
        coef_cur = bin_coef(3'(q.bin));
        op_a     = MUL_A_W'(s1_cur);
        op_b     = MUL_B_W'(coef_cur);
        base     = '0;
        sub      = '0;
        scale    = 1'b0;
        negate   = 1'b0;
        case (q.fsm)
            PH_UPDATE: begin
                // s = x + coef*s1 - s2
                scale = 1'b1;
                base  = ACC_W'($signed(q.x));
                sub   = ACC_W'(s2_cur);
            end
            PH_POWER: begin
                case (q.step)
                    2'd0: begin
                        op_b = MUL_B_W'(s1_cur);
                    end
                    2'd1: begin
                        op_a = MUL_A_W'(s2_cur);
                        op_b = MUL_B_W'(s2_cur);
                        base = $signed(q.acc);
                    end
                    2'd2: begin
                        scale = 1'b1;
                    end
                    default: begin
                        op_a   = $signed(q.tmp);
                        op_b   = MUL_B_W'(s2_cur);
                        base   = $signed(q.acc);
                        negate = 1'b1;
                    end
                endcase
            end
            default: ;
        endcase
    end

    // next-state computation
    always_comb begin
        d       = q;
        d.valid = 1'b0;
        case (q.fsm)
            PH_IDLE: begin
                if (sample_stb_i) begin
                    d.x   = sample_i;
                    d.bin = '0;
                    d.fsm = PH_UPDATE;
                end
            end
            PH_UPDATE: begin
                d.s1[q.bin] = mac_out[STATE_W-1:0];
                d.s2[q.bin] = q.s1[q.bin];
                if (q.bin == BIN_W'(NBIN - 1)) begin
                    d.bin = '0;
                    if (q.cnt == CNT_W'(FRAME_LEN - 1)) begin
                        d.cnt  = '0;
                        d.step = '0;
                        d.fsm  = PH_POWER;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                        d.fsm = PH_IDLE;
                    end
                end else begin
                    d.bin = q.bin + BIN_W'(1);
                end
            end
            PH_POWER: begin
                case (q.step)
                    2'd0, 2'd1: d.acc = mac_out;
                    2'd2:       d.tmp = mac_out[MUL_A_W-1:0];
                    default:    d.mag[q.bin] = to_mag(mac_out);
                endcase
                d.step = q.step + 2'd1;
                if (q.step == 2'd3) begin
                    if (q.bin == BIN_W'(NBIN - 1)) begin
                        d.bin = '0;
                        d.fsm = PH_DECIDE;
                    end else begin
                        d.bin = q.bin + BIN_W'(1);
                    end
                end
            end
            default: begin
                if (qualified) begin
                    d.digit = key_code(2'(win_idx[0]), 2'(win_idx[1]));
                    d.valid = 1'b1;
                end
                d.s1  = '0;
                d.s2  = '0;
                d.fsm = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign digit_o   = q.digit;
    assign valid_o   = q.valid;
    assign mag_o     = q.mag;
    assign state_vec = {q.s1, q.s2};
    assign fsm_now   = q.fsm;

endmodule

// File: rtl/dtmf_det_checker.sv
module dtmf_det_checker
    import dtmf_det_pkg::*;
#(
    parameter int NBIN    = 8,
    parameter int STATE_W = 24,
    parameter int MAG_W   = 48
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      sample_stb_i,
    input logic                      valid_i,
    input logic [3:0]                digit_i,
    input logic [NBIN*MAG_W-1:0]     mag_i,
    input logic [MAG_W-1:0]          min_mag_i,
    input phase_e                    fsm_i,
    input logic [2*NBIN*STATE_W-1:0] state_vec_i
);

    logic low_ok, high_ok;

    always_comb begin
        low_ok  = 1'b0;
        high_ok = 1'b0;
        for (int i = 0; i < NBIN / 2; i++) begin
            if (mag_i[i*MAG_W +: MAG_W] > min_mag_i) low_ok = 1'b1;
            if (mag_i[(i + NBIN/2)*MAG_W +: MAG_W] > min_mag_i) high_ok = 1'b1;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> !valid_i); // R4

    AST_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_stb_i |-> (fsm_i == PH_IDLE)); // R4

    AST_DIGIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |-> $stable(digit_i)); // R6

    AST_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |-> (low_ok && high_ok)); // R5

    AST_STATE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((fsm_i == PH_IDLE) && ($past(fsm_i) == PH_DECIDE)) |-> (state_vec_i == '0)); // R7

endmodule

bind dtmf_goertzel_detector dtmf_det_checker #(
    .NBIN    (NBIN),
    .STATE_W (STATE_W),
    .MAG_W   (MAG_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sample_stb_i (sample_stb_i),
    .valid_i      (valid_o),
    .digit_i      (digit_o),
    .mag_i        (mag_o),
    .min_mag_i    (min_mag_i),
    .fsm_i        (fsm_now),
    .state_vec_i  (state_vec)
);

// File: tb/dtmf_goertzel_detector_tb_top.sv
module dtmf_goertzel_detector_tb_top;

    localparam int SAMPLE_W = 12;
    localparam int MAG_W    = 48;
    localparam int NBIN     = 8;
    localparam int GAP      = 48;
    localparam real PI      = 3.14159265358979;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       stb = 1'b0;
    logic signed [SAMPLE_W-1:0] smp = '0;
    logic [MAG_W-1:0]           min_mag = '0;
    logic [3:0]                 digit;
    logic                       valid;
    logic [NBIN*MAG_W-1:0]      mags;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    int vcount = 0;
    int v_before, v_at41, v_at42, v_at43;

    int       lo_k [4] = '{18, 20, 22, 24};
    int       hi_k [4] = '{31, 34, 38, 42};
    logic [3:0] keymap [16] = '{4'h1, 4'h2, 4'h3, 4'hA,
                                4'h4, 4'h5, 4'h6, 4'hB,
                                4'h7, 4'h8, 4'h9, 4'hC,
                                4'hE, 4'h0, 4'hF, 4'hD};

    always #10 clk = ~clk;

    dtmf_goertzel_detector dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sample_stb_i (stb),
        .sample_i     (smp),
        .min_mag_i    (min_mag),
        .digit_o      (digit),
        .valid_o      (valid),
        .mag_o        (mags)
    );

    always @(negedge clk) begin
        if (valid) vcount++;
    end

    function automatic logic [MAG_W-1:0] mag_of(int i);
        return mags[i*MAG_W +: MAG_W];
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one frame of two tones; records valid timing around the final sample
    task automatic play_frame(input real amp_lo, input int klo, input real amp_hi, input int khi);
        vcount = 0;
        for (int n = 0; n < 128; n++) begin
            @(negedge clk);
            stb = 1'b1;
            smp = SAMPLE_W'(int'(amp_lo * $sin(2.0 * PI * klo * n / 128.0)
                               + amp_hi * $sin(2.0 * PI * khi * n / 128.0 + 0.7)));
            if (n == 127) v_before = vcount;
            @(negedge clk);
            stb = 1'b0;
            if (n == 127) begin
                repeat (40) @(negedge clk);
                v_at41 = valid;
                @(negedge clk);
                v_at42 = valid;
                @(negedge clk);
                v_at43 = valid;
                repeat (GAP - 44) @(negedge clk);
            end else begin
                repeat (GAP - 2) @(negedge clk);
            end
        end
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check(valid == 1'b0, "R1 valid in reset", valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid == 1'b0, "R1 valid after reset", valid, 0);
        check(digit == 4'h0, "R1 digit after reset", digit, 0);
        check(mags == '0, "R1 magnitudes after reset", (mags != '0), 0);
    endtask

    task automatic test_all_keys();
        min_mag = 48'd100_000_000;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                int lo_win;
                int hi_win;
                play_frame(900.0, lo_k[r], 900.0, hi_k[c]);
                check(v_before == 0, "R4 no early valid", v_before, 0);
                check(v_at41 == 0, "R4 valid before edge 41", v_at41, 0);
                check(v_at42 == 1, "R4 valid at edge 41", v_at42, 1);
                check(v_at43 == 0, "R4 valid one cycle", v_at43, 0);
                check(vcount == 1, "R4 one pulse per frame", vcount, 1);
                check(digit == keymap[r*4+c], "R2 R7 key code", digit, keymap[r*4+c]);
                lo_win = r;
                hi_win = 4 + c;
                for (int i = 0; i < 4; i++) begin
                    if (i != r && mag_of(i) >= mag_of(lo_win)) lo_win = i;
                    if (i != c && mag_of(4+i) >= mag_of(hi_win)) hi_win = 4 + i;
                end
                check(lo_win == r, "R3 low group peak bin", lo_win, r);
                check(hi_win == 4 + c, "R3 high group peak bin", hi_win, 4 + c);
            end
        end
    endtask

    task automatic test_threshold_high();
        min_mag = '1;
        play_frame(900.0, lo_k[1], 900.0, hi_k[1]);
        check(vcount == 0, "R5 no valid above threshold", vcount, 0);
        check(digit == 4'hD, "R6 digit held", digit, 4'hD);
    endtask

    task automatic test_single_tone();
        min_mag = 48'd100_000_000;
        play_frame(900.0, lo_k[2], 0.0, hi_k[0]);
        check(vcount == 0, "R5 single tone not reported", vcount, 0);
        check(digit == 4'hD, "R6 digit held after single tone", digit, 4'hD);
        check(mag_of(2) > min_mag, "R3 lone tone bin energy", mag_of(2) > min_mag, 1);
    endtask

    task automatic test_silence();
        min_mag = '0;
        play_frame(0.0, lo_k[0], 0.0, hi_k[0]);
        check(vcount == 0, "R5 silent frame strict compare", vcount, 0);
        for (int i = 0; i < NBIN; i++) begin
            check(mag_of(i) == '0, "R7 cleared state gives zero magnitude", mag_of(i), 0);
        end
        check(digit == 4'hD, "R6 digit held after silence", digit, 4'hD);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_all_keys();
        test_threshold_high();
        test_single_tone();
        test_silence();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule